// File: doc/BRIEF.md
# Command-Driven Half-Duplex SPI Master

This block is a register-mapped SPI master that runs one framed operation per command. Software fills up to eight byte slots and then writes a command word with two counts: the total number of byte times in the operation and how many of the leading ones carry data out. The engine sends those bytes from the slots, then clocks in the remaining byte times. It writes each received byte back into the slots, starting at slot 0, and reports how many bytes arrived.

A configuration register sets the serial clock divider, the clock idle level, the bit order, the chip-select polarity, a mask of usable chip selects and a count of idle serial periods that ends each command. A flag in the command word keeps the chosen chip select asserted after the command finishes. Several commands can therefore form one long transaction on the wire. While the block is disabled its pins are not driven.

Top module: `spi_burst_master`

## Requirements
- R1: After reset the config reads 0 and the status reads 0. The pin output-enable is low, every chip select sits at its inactive level (1, since polarity defaults to active-low), the serial clock idles high and the data-out line is 0.
- R2: Config bit 0 enables the block. While it is 0, `pins_oe` is low, all chip selects are inactive (including one held over from an earlier command), and a command write starts nothing.
- R3: A write to offset 0x10 starts an operation when the block is enabled and idle. The fields are total count at bits 4:0, transmit count at bits 12:8, hold flag at bit 16 and chip-select index at bits 21:20. Status bit 0 (busy) reads 1 from the clock edge that takes the write.
- R4: The first transmit-count byte times drive slots 0, 1, … onto `mosi_o`, one bit per serial period. The order is MSB first when config bit 4 is 0 and LSB first when it is 1. Receive-only byte times drive 0.
- R5: In each receive byte time the block samples `miso_i` using the same bit order and stores the byte in slot k for the k-th received byte. When busy falls, status bits 12:8 hold total minus transmit count. Slots that received nothing keep their contents.
- R6: Each serial clock half-period lasts D input clocks, where D is config bits 28:16 and 0 counts as 1. The first edge comes D clocks after the command. The clock idles low when config bit 1 is 1 and high otherwise. Data changes on the leading edge (leaving idle) and is sampled on the trailing edge.
- R7: While busy, exactly the chip select named by the index is active, and only if its bit in the enable mask (config bits 15:12) is set. The active level is high when config bit 7 is 1 and low when it is 0. When the command ends, the line is released unless the hold flag was set.
- R8: With idle count I (config bits 9:8), busy falls D·(2·I+1) input clocks after the last serial clock transition. With a total count of 0, busy falls that long after the command.
- R9: A command write while busy is ignored.
- R10: A total count above 8 is treated as 8. A transmit count above the (clamped) total is treated as the total.
- R11: Slot n sits at offset 0x80 + 8·n for n = 0..7. A write keeps bits 7:0, and a read returns them with bits 63:8 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational on `reg_addr`) |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |
| pins_oe | output | 1 | Output enable for serial clock, data out and chip selects |

## Verification
Busy is due on the edge that takes the command, so the bench reads status at the falling edge right after the write. The first serial clock transition is due D clocks later and each following one D clocks after that. The bench timestamps every transition at falling edges and compares each interval with D. Busy falls D·(2·I+1) clocks after the last transition, and the bench measures that gap against the same timestamps. Received bytes, the received count and the chip-select level are checked only once busy has read 0, and pin-level data is captured at trailing transitions, where R6 guarantees it is stable.

// File: rtl/spi_bm_pkg.sv
`timescale 1ns/1ps
package spi_bm_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] OFS_CFG   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CMD   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_SLOT0 = 8'h80;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SHIFT,
        ENG_GAP
    } eng_e;
endpackage

// File: rtl/spi_bm_clkdiv.sv
`timescale 1ns/1ps
module spi_bm_clkdiv #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q, lim;

    always_comb begin
        lim   = (div == '0) ? '0 : div - 1'b1;
        tick  = run && (cnt_q == lim);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6
    div_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));
endmodule

// File: rtl/spi_bm_csdrv.sv
`timescale 1ns/1ps
module spi_bm_csdrv #(
    parameter int NUM_CS = 4,
    parameter int SEL_W  = $clog2(NUM_CS)
) (
    input  logic              active,
    input  logic [SEL_W-1:0]  sel,
    input  logic [NUM_CS-1:0] mask,
    input  logic              act_high,
    output logic [NUM_CS-1:0] cs_o
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        logic hit;
        assign hit     = active && (sel == SEL_W'(i)) && mask[i];
        assign cs_o[i] = act_high ? hit : ~hit;
    end
endmodule

// File: rtl/spi_burst_master.sv
`timescale 1ns/1ps
module spi_burst_master
    import spi_bm_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int NUM_CS    = 4,
    parameter int DIV_W     = 13,
    parameter int REG_W     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic [NUM_CS-1:0] cs_o,
    output logic              pins_oe
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int CNT_W  = SLOT_W + 1;
    localparam int BIT_W  = CNT_W + 3;
    localparam int SEL_W  = $clog2(NUM_CS);
    localparam logic [7:0] SLOT_END = OFS_SLOT0 + 8'(8 * NUM_SLOTS);

    typedef struct packed {
        logic                       en;
        logic                       idle_low;
        logic                       lsb;
        logic                       cs_high;
        logic [1:0]                 idle;
        logic [NUM_CS-1:0]          mask;
        logic [DIV_W-1:0]           div;
        eng_e                       st;
        logic                       sclk;
        logic                       mosi;
        logic                       cs_act;
        logic [SEL_W-1:0]           sel;
        logic                       leave;
        logic [CNT_W-1:0]           tot;
        logic [CNT_W-1:0]           txn;
        logic [CNT_W-1:0]           rxnum;
        logic [BIT_W-1:0]           bitn;
        logic [7:0]                 rxb;
        logic [2:0]                 gap;
        logic [NUM_SLOTS-1:0][7:0]  slot;
    } state_t;

    state_t q, n;
    logic   tick;
    logic   idle_lvl, slot_hit, finish, end_cmd;
    logic [SLOT_W-1:0] slot_idx;
    logic [CNT_W-1:0]  cur_byte;
    logic [2:0]        bit_pos;
    logic [7:0]        rx_next;
    logic [4:0]        req_tot, req_txn, tot_c, txn_c;
    logic              unused_wdata;

    assign unused_wdata = ^{reg_wdata[REG_W-1:16+DIV_W], reg_wdata[11:10],
                            reg_wdata[6:5], reg_wdata[3:2]};

    spi_bm_clkdiv #(.DIV_W(DIV_W)) i_clkdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.st != ENG_IDLE),
        .div   (q.div),
        .tick  (tick)
    );

    spi_bm_csdrv #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) i_csdrv (
        .active   (q.cs_act),
        .sel      (q.sel),
        .mask     (q.mask),
        .act_high (q.cs_high),
        .cs_o     (cs_o)
    );

    always_comb begin
        slot_hit = (reg_addr >= OFS_SLOT0) && (reg_addr < SLOT_END) && (reg_addr[2:0] == 3'b000);
        slot_idx = SLOT_W'((reg_addr - OFS_SLOT0) >> 3);
    end

    always_comb begin
        n        = q;
        idle_lvl = ~q.idle_low;
        cur_byte = q.bitn[BIT_W-1:3];
        bit_pos  = q.lsb ? q.bitn[2:0] : ~q.bitn[2:0];
        rx_next  = q.lsb ? {miso_i, q.rxb[7:1]} : {q.rxb[6:0], miso_i};
        finish   = 1'b0;
        end_cmd  = 1'b0;
        req_tot  = reg_wdata[4:0];
        req_txn  = reg_wdata[12:8];
        tot_c    = (req_tot > 5'(NUM_SLOTS)) ? 5'(NUM_SLOTS) : req_tot;
        txn_c    = (req_txn > tot_c) ? tot_c : req_txn;

        case (q.st)
            ENG_SHIFT: if (tick) begin
                if (q.bitn == {q.tot, 3'b000}) begin
                    finish = 1'b1;
                end else if (q.sclk == idle_lvl) begin
                    n.sclk = ~idle_lvl;
                    n.mosi = (cur_byte < q.txn) ? q.slot[cur_byte[SLOT_W-1:0]][bit_pos] : 1'b0;
                end else begin
                    n.sclk = idle_lvl;
                    n.rxb  = rx_next;
                    n.bitn = q.bitn + 1'b1;
                    if ((q.bitn[2:0] == 3'd7) && (cur_byte >= q.txn))
                        n.slot[SLOT_W'(cur_byte - q.txn)] = rx_next;
                end
            end
            ENG_GAP: if (tick) begin
                if (q.gap == 3'd0) end_cmd = 1'b1;
                else               n.gap   = q.gap - 3'd1;
            end
            default: ;
        endcase

        if (finish) begin
            if (q.idle == 2'd0) begin
                end_cmd = 1'b1;
            end else begin
                n.st  = ENG_GAP;
                n.gap = {q.idle, 1'b0} - 3'd1;
            end
        end

        if (end_cmd) begin
            n.st    = ENG_IDLE;
            n.mosi  = 1'b0;
            n.rxnum = q.tot - q.txn;
            if (!q.leave) n.cs_act = 1'b0;
        end

        if (reg_wr) begin
            if (reg_addr == OFS_CFG) begin
                n.en       = reg_wdata[0];
                n.idle_low = reg_wdata[1];
                n.lsb      = reg_wdata[4];
                n.cs_high  = reg_wdata[7];
                n.idle     = reg_wdata[9:8];
                n.mask     = reg_wdata[12 +: NUM_CS];
                n.div      = reg_wdata[16 +: DIV_W];
                if (!reg_wdata[0]) begin
                    n.st     = ENG_IDLE;
                    n.cs_act = 1'b0;
                    n.mosi   = 1'b0;
                end
            end else if (reg_addr == OFS_CMD) begin
                if ((q.st == ENG_IDLE) && q.en) begin
                    n.st     = ENG_SHIFT;
                    n.tot    = CNT_W'(tot_c);
                    n.txn    = CNT_W'(txn_c);
                    n.leave  = reg_wdata[16];
                    n.sel    = reg_wdata[20 +: SEL_W];
                    n.cs_act = 1'b1;
                    n.bitn   = '0;
                    n.rxnum  = '0;
                    n.sclk   = idle_lvl;
                    n.mosi   = 1'b0;
                end
            end else if (slot_hit) begin
                n.slot[slot_idx] = reg_wdata[7:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_CFG) begin
            reg_rdata[0]             = q.en;
            reg_rdata[1]             = q.idle_low;
            reg_rdata[4]             = q.lsb;
            reg_rdata[7]             = q.cs_high;
            reg_rdata[9:8]           = q.idle;
            reg_rdata[12 +: NUM_CS]  = q.mask;
            reg_rdata[16 +: DIV_W]   = q.div;
        end else if (reg_addr == OFS_STAT) begin
            reg_rdata[0]    = (q.st != ENG_IDLE);
            reg_rdata[12:8] = 5'(q.rxnum);
        end else if (slot_hit) begin
            reg_rdata[7:0] = q.slot[slot_idx];
        end
    end

    assign sclk_o  = (q.st == ENG_IDLE) ? ~q.idle_low : q.sclk;
    assign mosi_o  = q.mosi;
    assign pins_oe = q.en;

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CMD && q.st == ENG_IDLE && q.en) |=> (q.st != ENG_IDLE));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CMD && q.st != ENG_IDLE)
        |=> ($stable(q.tot) && $stable(q.txn) && $stable(q.leave) && $stable(q.sel)));

    // R10
    count_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.tot <= CNT_W'(NUM_SLOTS)) && (q.txn <= q.tot));

    // R2
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.en |-> (q.st == ENG_IDLE && cs_o == {NUM_CS{~q.cs_high}}));

    // R7
    cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ENG_IDLE && q.mask[q.sel]) |-> ($countones(cs_o ^ {NUM_CS{~q.cs_high}}) == 1));

    // R6
    sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ENG_SHIFT && !tick) |=> $stable(q.sclk));

    // R5
    rxnum_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ENG_IDLE) |-> (q.rxnum == '0));
endmodule

// File: tb/test_spi_burst_master.sv
`timescale 1ns/1ps
module test_spi_burst_master;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CFG = 8'h00, A_STAT = 8'h08, A_CMD = 8'h10, A_SLOT = 8'h80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        sclk_o, mosi_o, pins_oe;
    logic        miso_i = 1'b0;
    logic [3:0]  cs_o;

    spi_burst_master i_spi_burst_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk_o(sclk_o),
        .mosi_o(mosi_o), .miso_i(miso_i), .cs_o(cs_o), .pins_oe(pins_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int     n_checks = 0, n_fail = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    bit cf_idle_low, cf_lsb, cf_hi;
    int cf_idle, cf_d;
    logic [7:0] tx_data [8];
    logic [7:0] sl_data [8];
    logic [7:0] mon_mosi [8];
    int     bitcnt;
    bit     mon_on = 0;
    logic   prev_sclk = 1'b1;
    longint last_trans, hp_min, hp_max;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on && pins_oe && sclk_o !== prev_sclk) begin
            longint hp;
            int bi, bp;
            hp = cyc - last_trans;
            if (hp < hp_min) hp_min = hp;
            if (hp > hp_max) hp_max = hp;
            last_trans = cyc;
            bi = bitcnt / 8;
            bp = cf_lsb ? (bitcnt % 8) : (7 - bitcnt % 8);
            if (sclk_o != ~cf_idle_low) begin
                if (bi < 8) miso_i = sl_data[bi][bp];
            end else begin
                if (bi < 8) mon_mosi[bi][bp] = mosi_o;
                bitcnt++;
            end
        end
        prev_sclk = sclk_o;
    end

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    function automatic logic [3:0] exp_cs(input int sel, input bit hi, input bit act);
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = hi ? (act && i == sel) : ~(act && i == sel);
        return v;
    endfunction

    function automatic int min2(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic set_cfg(input bit en, input bit il, input bit lsb, input bit hi,
                           input int idle, input int div);
        logic [63:0] v;
        v = '0; v[0] = en; v[1] = il; v[4] = lsb; v[7] = hi;
        v[9:8] = idle[1:0]; v[15:12] = 4'hF; v[28:16] = div[12:0];
        cf_idle_low = il; cf_lsb = lsb; cf_hi = hi; cf_idle = idle;
        cf_d = (div == 0) ? 1 : div;
        wr(A_CFG, v);
    endtask

    task automatic run_cmd(input int tot, input int txn, input bit leave, input int sel, input bit intrude);
        int te, xe;
        bit done;
        longint fall;
        logic [63:0] d, cmd;
        te = min2(tot, 8);
        xe = min2(txn, te);
        for (int j = 0; j < 8; j++) wr(A_SLOT + 8'(8*j), {56'hABCDEF_0123_4567, tx_data[j]});
        for (int j = 0; j < 8; j++) mon_mosi[j] = 8'h5A;
        bitcnt = 0; hp_min = 64'h7FFF_FFFF; hp_max = 0; mon_on = 1;
        cmd = '0; cmd[4:0] = tot[4:0]; cmd[12:8] = txn[4:0]; cmd[16] = leave; cmd[21:20] = sel[1:0];
        wr(A_CMD, cmd);
        reg_addr = A_STAT;
        last_trans = cyc;
        #1;
        chk("R3", "busy after command", reg_rdata[0], 1);
        chk("R7", "cs during command", cs_o, exp_cs(sel, cf_hi, 1));
        if (intrude) begin
            wr(A_CMD, 64'h0001_0008);
            reg_addr = A_STAT;
        end
        done = 0;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (!reg_rdata[0]) begin done = 1; break; end
        end
        fall = cyc;
        mon_on = 0;
        chk("R3", "busy cleared", done, 1);
        chk("R8", "idle gap cycles", fall - last_trans, cf_d * (2*cf_idle + 1));
        chk(intrude ? "R9" : "R6", "serial bits", bitcnt, te*8);
        if (te > 0) begin
            chk("R6", "min half period", hp_min, cf_d);
            chk("R6", "max half period", hp_max, cf_d);
        end
        for (int j = 0; j < te; j++)
            chk("R4", $sformatf("mosi byte %0d", j), mon_mosi[j], (j < xe) ? tx_data[j] : 8'h00);
        chk("R7", "cs after command", cs_o, exp_cs(sel, cf_hi, leave));
        rd(A_STAT, d);
        chk(intrude ? "R9" : "R5", "rx count", d[12:8], te - xe);
        chk("R5", "status busy", d[0], 0);
        for (int j = 0; j < 8; j++) begin
            rd(A_SLOT + 8'(8*j), d);
            chk((tot > 8 || txn > tot) ? "R10" : "R5", $sformatf("slot %0d", j), d,
                {56'h0, (j < te - xe) ? sl_data[xe + j] : tx_data[j]});
        end
    endtask

    task automatic fill_data();
        for (int j = 0; j < 8; j++) begin
            tx_data[j] = 8'($urandom);
            sl_data[j] = 8'($urandom);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R3 watchdog expired: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] d;
        void'($urandom(32'h5EED_0042));
        cf_idle_low = 0; cf_lsb = 0; cf_hi = 0; cf_idle = 0; cf_d = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd(A_CFG, d);  chk("R1", "cfg reset", d, 0);
        rd(A_STAT, d); chk("R1", "status reset", d, 0);
        chk("R1", "oe reset", pins_oe, 0);
        chk("R1", "cs reset", cs_o, 4'hF);
        chk("R1", "sclk reset", sclk_o, 1);
        chk("R1", "mosi reset", mosi_o, 0);

        wr(A_SLOT + 8'h18, 64'hFFFF_FFFF_FFFF_FFA5);
        rd(A_SLOT + 8'h18, d); chk("R11", "slot low byte", d, 64'hA5);

        set_cfg(1, 1, 0, 0, 0, 5);
        chk("R6", "clock idles low", sclk_o, 0);
        chk("R2", "oe enabled", pins_oe, 1);

        fill_data(); set_cfg(1, 0, 0, 0, 0, 2); run_cmd(3, 3, 0, 0, 0);
        fill_data(); set_cfg(1, 0, 1, 0, 2, 3); run_cmd(4, 1, 1, 2, 0);
        fill_data(); set_cfg(1, 1, 0, 1, 1, 1); run_cmd(0, 0, 0, 1, 0);
        fill_data(); set_cfg(1, 0, 0, 0, 0, 1); run_cmd(20, 25, 0, 3, 0);
        fill_data(); set_cfg(1, 1, 1, 1, 3, 2); run_cmd(5, 9, 0, 0, 0);
        fill_data(); set_cfg(1, 0, 0, 0, 1, 0); run_cmd(31, 0, 0, 1, 0);
        fill_data(); set_cfg(1, 0, 0, 0, 0, 2); run_cmd(2, 2, 0, 0, 1);

        fill_data(); set_cfg(1, 0, 0, 0, 0, 1); run_cmd(1, 1, 1, 3, 0);
        set_cfg(0, 0, 0, 0, 0, 1);
        chk("R2", "oe disabled", pins_oe, 0);
        chk("R2", "held cs released", cs_o, 4'hF);
        wr(A_CMD, 64'h0000_0404);
        rd(A_STAT, d); chk("R2", "cmd ignored when disabled", d[0], 0);

        for (int it = 0; it < 12; it++) begin
            fill_data();
            set_cfg(1, 1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 4), int'($urandom % 5));
            run_cmd(int'($urandom % 11), int'($urandom % 11), 1'($urandom), int'($urandom % 4), 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule